// File: doc/BRIEF.md
# Ingress VLAN Tag Classifier and Frame Admission

This block sits behind an ingress header parser. For every frame it receives the EtherType of the outer and inner tag positions together with the outer tag control word, and decides in one registered stage whether the frame carries no tag, a priority tag (VID 0), one VLAN tag or two stacked tags. A tag position is recognised by comparing its EtherType against three programmable tag EtherTypes; each of these has its own enable for the outer position and its own enable for the inner position.

The resolved class then meets a three-bit acceptance filter (untagged, priority-tagged, tagged) that produces an admit flag, and a VID is resolved: frames without a usable VID take the port default VID, tagged frames report their outer VID. A two-bit selector also picks which of the three EtherTypes is presented for tags pushed at ingress. Configuration lives in a small write-only register file inside the block, with defined reset values.

Top module: `vlan_ingress_cls`

## Requirements
- R1: After reset the tag EtherTypes are 0x8100, 0x88A8 and 0x9100 (index 0, 1, 2); outer and inner enables are set for index 0 and 1 and clear for index 2; all three acceptance bits are set; the port default VID is 1; the push selector is 0; `out_valid_o` is 0.
- R2: A frame whose outer EtherType equals an EtherType with its outer enable set is tagged; otherwise it is classified untagged (class code 0). A tagged frame with nonzero VID and no inner match is single-tagged (code 2).
- R3: A tagged frame with nonzero outer VID whose inner EtherType equals an EtherType with its inner enable set is double-tagged (code 3).
- R4: A tagged frame whose outer VID (`tag0_tci_i[11:0]`) is 0 is priority-tagged (code 1), whatever its inner tag.
- R5: Untagged and priority-tagged frames report the port default VID; single- and double-tagged frames report the outer VID.
- R6: `out_admit_o` equals acceptance bit 0 for untagged, bit 1 for priority-tagged and bit 2 for single- or double-tagged frames.
- R7: `push_etype_o` shows EtherType 0, 1 or 2 for selector values 0, 1, 2; selector value 3 shows EtherType 0.
- R8: Every frame presented with `in_valid_i` high appears with `out_valid_o` high exactly one cycle later; `out_valid_o` is low one cycle after a cycle with `in_valid_i` low.
- R9: A configuration write in the same cycle as a frame takes effect for later frames only; that frame uses the previous settings.
- R10: Writes with `cfg_addr_i` 0..2 load EtherType k from data bits [15:0], its outer enable from bit 16 and its inner enable from bit 17. Address 3 loads the default VID from bits [11:0], acceptance bits untagged/priority/tagged from bits 20/21/22 and the push selector from bits [25:24].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | 32 | Configuration write data |
| in_valid_i | input | 1 | Parsed header fields valid |
| tag0_etype_i | input | 16 | EtherType at outer tag position |
| tag0_tci_i | input | 16 | Outer tag control word (VID in [11:0]) |
| tag1_etype_i | input | 16 | EtherType at inner tag position |
| out_valid_o | output | 1 | Classification result valid |
| out_class_o | output | 2 | 0 untagged, 1 priority, 2 single, 3 double |
| out_vid_o | output | 12 | Resolved VID |
| out_admit_o | output | 1 | 1 admit, 0 drop |
| push_etype_o | output | 16 | EtherType selected for ingress push |

## Verification
The hardest situations are those where enable state and EtherType value disagree: a frame carrying 0x9100 must stay untagged until index 2 is enabled, and an inner 0x9100 must not make a frame double-tagged while only the outer enable of index 2 is set. The stimulus reaches them by reprogramming enables one position at a time and sending the same header mix before and after, then by retargeting an EtherType value so the old value stops matching. A configuration write is also issued in the very cycle of a frame to show the frame still sees the old settings, and a long random mix of headers drawn from matching and non-matching EtherTypes covers the remaining combinations against the bench model.

// File: rtl/vlan_cls_pkg.sv
package vlan_cls_pkg;
  localparam int NUM_ET = 3;
  localparam int SEL_W  = 2;
  localparam int CFG_AW = 2;
  localparam int CFG_DW = 32;
  // configuration word bit positions
  localparam int OEN_BIT   = 16;
  localparam int IEN_BIT   = 17;
  localparam int ALLOW_LSB = 20;
  localparam int SEL_LSB   = 24;

  typedef enum logic [1:0] {
    CLS_UNTAG  = 2'd0,
    CLS_PRIO   = 2'd1,
    CLS_SINGLE = 2'd2,
    CLS_DOUBLE = 2'd3
  } tag_class_e;
endpackage

// File: rtl/vlan_cfg_regs.sv
module vlan_cfg_regs
  import vlan_cls_pkg::*;
#(
  parameter int ETYPE_W = 16,
  parameter int VID_W   = 12,
  parameter logic [NUM_ET*ETYPE_W-1:0] ET_RST = {16'h9100, 16'h88A8, 16'h8100},
  parameter logic [NUM_ET-1:0] OEN_RST = 3'b011,
  parameter logic [NUM_ET-1:0] IEN_RST = 3'b011,
  parameter logic [VID_W-1:0]  PVID_RST = 12'd1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CFG_AW-1:0]                addr_i,
  input  logic [CFG_DW-1:0]                wdata_i,
  output logic [NUM_ET-1:0][ETYPE_W-1:0]   et_o,
  output logic [NUM_ET-1:0]                oen_o,
  output logic [NUM_ET-1:0]                ien_o,
  output logic [VID_W-1:0]                 pvid_o,
  output logic [2:0]                       allow_o,
  output logic [SEL_W-1:0]                 sel_o
);
  localparam logic [CFG_AW-1:0] PORT_ADDR = CFG_AW'(NUM_ET);

  for (genvar k = 0; k < NUM_ET; k++) begin : g_et
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        et_o[k]  <= ET_RST[k*ETYPE_W +: ETYPE_W];
        oen_o[k] <= OEN_RST[k];
        ien_o[k] <= IEN_RST[k];
      end else if (we_i && addr_i == CFG_AW'(k)) begin
        et_o[k]  <= wdata_i[ETYPE_W-1:0];
        oen_o[k] <= wdata_i[OEN_BIT];
        ien_o[k] <= wdata_i[IEN_BIT];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pvid_o  <= PVID_RST;
      allow_o <= 3'b111;
      sel_o   <= '0;
    end else if (we_i && addr_i == PORT_ADDR) begin
      pvid_o  <= wdata_i[VID_W-1:0];
      allow_o <= wdata_i[ALLOW_LSB +: 3];
      sel_o   <= wdata_i[SEL_LSB +: SEL_W];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[CFG_DW-1:SEL_LSB+SEL_W], wdata_i[ALLOW_LSB-1:IEN_BIT+1]};
endmodule

// File: rtl/vlan_tag_match.sv
module vlan_tag_match
  import vlan_cls_pkg::*;
#(
  parameter int ETYPE_W = 16
) (
  input  logic [NUM_ET-1:0][ETYPE_W-1:0] et_i,
  input  logic [NUM_ET-1:0]              oen_i,
  input  logic [NUM_ET-1:0]              ien_i,
  input  logic [ETYPE_W-1:0]             tag0_etype_i,
  input  logic [ETYPE_W-1:0]             tag1_etype_i,
  output logic                           outer_hit_o,
  output logic                           inner_hit_o
);
  logic [NUM_ET-1:0] o_hit, i_hit;

  for (genvar k = 0; k < NUM_ET; k++) begin : g_cmp
    assign o_hit[k] = oen_i[k] && (tag0_etype_i == et_i[k]);
    assign i_hit[k] = ien_i[k] && (tag1_etype_i == et_i[k]);
  end

  assign outer_hit_o = |o_hit;
  assign inner_hit_o = |i_hit;
endmodule

// File: rtl/vlan_admit_stage.sv
module vlan_admit_stage
  import vlan_cls_pkg::*;
#(
  parameter int VID_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             outer_hit_i,
  input  logic             inner_hit_i,
  input  logic [VID_W-1:0] outer_vid_i,
  input  logic [VID_W-1:0] pvid_i,
  input  logic [2:0]       allow_i,
  output logic             valid_o,
  output tag_class_e       class_o,
  output logic [VID_W-1:0] vid_o,
  output logic             admit_o
);
  tag_class_e       cls_d;
  logic [VID_W-1:0] vid_d;
  logic             admit_d;

  always_comb begin
    if (!outer_hit_i)               cls_d = CLS_UNTAG;
    else if (outer_vid_i == '0)     cls_d = CLS_PRIO;
    else if (inner_hit_i)           cls_d = CLS_DOUBLE;
    else                            cls_d = CLS_SINGLE;

    unique case (cls_d)
      CLS_UNTAG:  begin vid_d = pvid_i;      admit_d = allow_i[0]; end
      CLS_PRIO:   begin vid_d = pvid_i;      admit_d = allow_i[1]; end
      default:    begin vid_d = outer_vid_i; admit_d = allow_i[2]; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      class_o <= CLS_UNTAG;
      vid_o   <= '0;
      admit_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        class_o <= cls_d;
        vid_o   <= vid_d;
        admit_o <= admit_d;
      end
    end
  end
endmodule

// File: rtl/vlan_ingress_cls.sv
module vlan_ingress_cls
  import vlan_cls_pkg::*;
#(
  parameter int ETYPE_W = 16,
  parameter int TCI_W   = 16,
  parameter int VID_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [CFG_DW-1:0]  cfg_wdata_i,
  input  logic               in_valid_i,
  input  logic [ETYPE_W-1:0] tag0_etype_i,
  input  logic [TCI_W-1:0]   tag0_tci_i,
  input  logic [ETYPE_W-1:0] tag1_etype_i,
  output logic               out_valid_o,
  output logic [1:0]         out_class_o,
  output logic [VID_W-1:0]   out_vid_o,
  output logic               out_admit_o,
  output logic [ETYPE_W-1:0] push_etype_o
);
  logic [NUM_ET-1:0][ETYPE_W-1:0] et_w;
  logic [NUM_ET-1:0]              oen_w, ien_w;
  logic [VID_W-1:0]               pvid_w;
  logic [2:0]                     allow_w;
  logic [SEL_W-1:0]               sel_w;
  logic                           outer_hit_w, inner_hit_w;
  tag_class_e                     class_w;

  vlan_cfg_regs #(.ETYPE_W(ETYPE_W), .VID_W(VID_W)) cfg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .et_o    (et_w),
    .oen_o   (oen_w),
    .ien_o   (ien_w),
    .pvid_o  (pvid_w),
    .allow_o (allow_w),
    .sel_o   (sel_w)
  );

  vlan_tag_match #(.ETYPE_W(ETYPE_W)) match_i (
    .et_i         (et_w),
    .oen_i        (oen_w),
    .ien_i        (ien_w),
    .tag0_etype_i (tag0_etype_i),
    .tag1_etype_i (tag1_etype_i),
    .outer_hit_o  (outer_hit_w),
    .inner_hit_o  (inner_hit_w)
  );

  vlan_admit_stage #(.VID_W(VID_W)) stage_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (in_valid_i),
    .outer_hit_i (outer_hit_w),
    .inner_hit_i (inner_hit_w),
    .outer_vid_i (tag0_tci_i[VID_W-1:0]),
    .pvid_i      (pvid_w),
    .allow_i     (allow_w),
    .valid_o     (out_valid_o),
    .class_o     (class_w),
    .vid_o       (out_vid_o),
    .admit_o     (out_admit_o)
  );

  assign out_class_o = class_w;

  // out-of-range selector falls back to index 0
  always_comb begin
    push_etype_o = et_w[0];
    for (int k = 1; k < NUM_ET; k++)
      if (int'(sel_w) == k) push_etype_o = et_w[k];
  end

  logic unused_tci;
  assign unused_tci = ^tag0_tci_i[TCI_W-1:VID_W];
endmodule

// File: rtl/vlan_ingress_cls_chk.sv
module vlan_ingress_cls_chk
  import vlan_cls_pkg::*;
#(
  parameter int TCI_W = 16,
  parameter int VID_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [TCI_W-1:0] tag0_tci_i,
  input logic             out_valid_o,
  input logic [1:0]       out_class_o,
  input logic [VID_W-1:0] out_vid_o,
  input logic             out_admit_o,
  input logic [2:0]       allow_i
);
  assert_valid_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_idle_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_single_vid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_class_o == CLS_SINGLE) |-> out_vid_o == $past(tag0_tci_i[VID_W-1:0]));

  assert_prio_zero_vid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_class_o == CLS_PRIO) |-> $past(tag0_tci_i[VID_W-1:0]) == '0);

  assert_admit_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_admit_o == ((out_class_o == CLS_UNTAG) ? $past(allow_i[0]) :
                                    (out_class_o == CLS_PRIO)  ? $past(allow_i[1]) :
                                                                 $past(allow_i[2])));
endmodule

bind vlan_ingress_cls vlan_ingress_cls_chk #(.TCI_W(TCI_W), .VID_W(VID_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .tag0_tci_i  (tag0_tci_i),
  .out_valid_o (out_valid_o),
  .out_class_o (out_class_o),
  .out_vid_o   (out_vid_o),
  .out_admit_o (out_admit_o),
  .allow_i     (allow_w)
);

// File: tb/vlan_ingress_cls_tb_top.sv
module vlan_ingress_cls_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [15:0] tag0_etype = '0, tag0_tci = '0, tag1_etype = '0;
  logic        out_valid, out_admit;
  logic [1:0]  out_class;
  logic [11:0] out_vid;
  logic [15:0] push_etype;

  always #4 clk = ~clk;

  vlan_ingress_cls dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .in_valid_i(in_valid), .tag0_etype_i(tag0_etype),
    .tag0_tci_i(tag0_tci), .tag1_etype_i(tag1_etype), .out_valid_o(out_valid),
    .out_class_o(out_class), .out_vid_o(out_vid), .out_admit_o(out_admit),
    .push_etype_o(push_etype)
  );

  int  n_chk = 0, n_err = 0;
  bit  done = 0;
  // reference model state
  int  m_et[3];
  bit  m_oen[3], m_ien[3];
  int  m_pvid, m_sel;
  bit  m_au, m_ap, m_at;
  bit  e_valid = 0, e_admit;
  int  e_cls, e_vid;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_et = '{32'h8100, 32'h88A8, 32'h9100};
    m_oen = '{1, 1, 0};
    m_ien = '{1, 1, 0};
    m_pvid = 1; m_sel = 0;
    m_au = 1; m_ap = 1; m_at = 1;
  endtask

  task automatic check_outputs();
    string r;
    chk("R8 out_valid", int'(out_valid), int'(e_valid));
    if (e_valid) begin
      r = (e_cls == 3) ? "R3 class" : (e_cls == 1) ? "R4 class" : "R2 class";
      chk(r, int'(out_class), e_cls);
      chk("R5 vid", int'(out_vid), e_vid);
      chk("R6 admit", int'(out_admit), int'(e_admit));
    end
    chk("R7 push etype", int'(push_etype), m_et[(m_sel < 3) ? m_sel : 0]);
  endtask

  // one cycle: check previous result, drive frame and optional write (R9: model uses old cfg)
  task automatic step(bit v, int e0 = 0, int tci = 0, int e1 = 0,
                      bit we = 0, int a = 0, logic [31:0] d = '0);
    bit ohit, ihit;
    @(negedge clk);
    check_outputs();
    in_valid = v; tag0_etype = 16'(e0); tag0_tci = 16'(tci); tag1_etype = 16'(e1);
    cfg_we = we; cfg_addr = 2'(a); cfg_wdata = d;
    ohit = 0; ihit = 0;
    foreach (m_et[k]) begin
      if (m_oen[k] && (e0 & 16'hFFFF) == m_et[k]) ohit = 1;
      if (m_ien[k] && (e1 & 16'hFFFF) == m_et[k]) ihit = 1;
    end
    e_valid = v;
    if (v) begin
      if (!ohit)                     begin e_cls = 0; e_vid = m_pvid;        e_admit = m_au; end
      else if ((tci & 12'hFFF) == 0) begin e_cls = 1; e_vid = m_pvid;        e_admit = m_ap; end
      else if (ihit)                 begin e_cls = 3; e_vid = tci & 12'hFFF; e_admit = m_at; end
      else                           begin e_cls = 2; e_vid = tci & 12'hFFF; e_admit = m_at; end
    end
    if (we) begin // R10 map
      if (a < 3) begin
        m_et[a] = int'(d[15:0]); m_oen[a] = d[16]; m_ien[a] = d[17];
      end else begin
        m_pvid = int'(d[11:0]); m_au = d[20]; m_ap = d[21]; m_at = d[22];
        m_sel = int'(d[25:24]);
      end
    end
  endtask

  function automatic logic [31:0] port_word(int pvid, bit au, bit ap, bit at, int sel);
    return {6'd0, 2'(sel), 1'b0, at, ap, au, 8'd0, 12'(pvid)};
  endfunction

  initial begin
    int pick[5];
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at the ports
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 push etype after reset", int'(push_etype), 16'h8100);

    // R1/R2/R3/R4/R5: default EtherTypes
    step(1, 16'h0800, 16'h0123, 0);           // untagged, takes pvid 1
    step(1, 16'h8100, 16'h0005, 16'h0800);    // single
    step(1, 16'h88A8, 16'h0064, 16'h8100);    // double
    step(1, 16'h9100, 16'h0064, 16'h8100);    // R1: index 2 disabled -> untagged
    step(1, 16'h8100, 16'hE000, 16'h8100);    // R4: VID 0 -> priority even with inner tag
    step(1, 16'h8100, 16'h0FFF, 16'h9100);    // inner index 2 disabled -> single
    step(0);
    step(0);                                  // R8 idle

    // R10: enable only outer of index 2
    step(0, 0, 0, 0, 1, 2, 32'h0001_9100);
    step(1, 16'h9100, 16'h0200, 16'h0800);    // now single
    step(1, 16'h8100, 16'h0200, 16'h9100);    // inner not enabled -> single
    step(0, 0, 0, 0, 1, 2, 32'h0003_9100);
    step(1, 16'h8100, 16'h0201, 16'h9100);    // R3 double now
    // retarget index 1 value, outer only
    step(0, 0, 0, 0, 1, 1, 32'h0001_1234);
    step(1, 16'h88A8, 16'h0010, 0);           // old value no longer matches
    step(1, 16'h1234, 16'h0010, 16'h1234);    // inner of index 1 disabled -> single

    // R6: disallow each class in turn
    step(0, 0, 0, 0, 1, 3, port_word(12'hABC, 0, 1, 1, 0));
    step(1, 16'h0800, 16'h0005, 0);
    step(1, 16'h8100, 16'h0000, 0);
    step(1, 16'h8100, 16'h0005, 0);
    step(0, 0, 0, 0, 1, 3, port_word(12'hABC, 1, 0, 1, 1));
    step(1, 16'h8100, 16'h3000, 0);           // priority dropped, pvid 0xABC (R5)
    step(1, 16'h0800, 16'h0005, 0);
    step(0, 0, 0, 0, 1, 3, port_word(12'h7, 1, 1, 0, 2));
    step(1, 16'h8100, 16'h0005, 0);           // single dropped
    step(1, 16'h88A8, 16'h0005, 16'h8100);
    step(1, 16'h8100, 16'h0005, 16'h9100);    // double dropped
    // R7: selector value 3 falls back to index 0
    step(0, 0, 0, 0, 1, 3, port_word(12'h7, 1, 1, 1, 3));
    step(0);
    // R9: write in the same cycle as a frame
    step(1, 16'h0800, 16'h0001, 0, 1, 3, port_word(12'h555, 0, 0, 0, 1));
    step(1, 16'h0800, 16'h0001, 0);
    step(1, 16'h8100, 16'h0001, 0, 1, 3, port_word(12'h321, 1, 1, 1, 2));
    step(1, 16'h8100, 16'h0001, 0);

    // random mix covering R2..R6 with occasional reprogramming
    for (int i = 0; i < 400; i++) begin
      pick = '{16'h8100, 16'h88A8, 16'h9100, 16'h0800, m_et[1]};
      if ($urandom_range(0, 15) == 0)
        step($urandom_range(0, 1) == 1, pick[$urandom_range(0, 4)], $urandom_range(0, 3),
             pick[$urandom_range(0, 4)], 1, $urandom_range(0, 3), $urandom);
      else
        step($urandom_range(0, 4) != 0, pick[$urandom_range(0, 4)],
             ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 16'hFFFF),
             pick[$urandom_range(0, 4)]);
    end
    step(0);
    step(0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule